// File: doc/BRIEF.md
# Per-Channel High-Impedance Control Serializer

This block produces two serial control lines. An external buffer uses them to decide, one channel at a time, whether to drive or to float each of eight 512-channel data streams. Each control line runs at half the data-stream bit rate, and each control clock period carries one bit. Line 0 serves the even-numbered streams and line 1 serves the odd-numbered streams, so a frame of 2048 control periods covers every channel of all eight streams. Each bit is a copy of that channel's output-enable bit, which the block reads from an external connection memory. A one means the buffer drives the channel and a zero means it floats.

A bit goes out a fixed ten periods before the data channel it governs. The schedule therefore wraps around the frame boundary: the first bits of channel 0 leave near the end of the previous frame. The block fetches each enable bit three periods before its slot. The fetch uses a one-cycle read interface and a one-slot prefetch register. A sequencer state machine tracks frame alignment. It has three states:
- `ST_HUNT`: waiting for a frame pulse.
- `ST_PRIME`: the three periods after alignment, while the fetch pipeline fills.
- `ST_LOCKED`: normal operation.

Its transitions are:
- hunt-to-prime on any frame pulse.
- prime-to-locked after three periods.
- prime-or-locked back to prime on a frame pulse that arrives out of position.
- any state to hunt on reset.

Top module: `hz_ctl_serializer`

## Requirements
- R1: `ctl_o[0]` carries the enable bit of stream 2g and `ctl_o[1]` carries the enable bit of stream 2g+1, for the same channel and stream pair g. Each is a copy of the bit returned on `rd_oe[0]` and `rd_oe[1]` respectively, and 0 means float.
- R2: Periods are numbered 1 to 2048, and period 1 is the first period after the frame pulse cycle. Period P carries slot k = (P + 9) mod 2048, with channel = k / 4 and stream pair g = k mod 4.
- R3: Stream 0 channel 0 is sent in period 2039. Streams 6 and 7 channel 0 are sent in period 2042. Stream 3 channel 5 is sent in period 12. Stream 2 channel 511 is sent in period 2036.
- R4: In every period after alignment, `rd_en` is 1 and `{rd_chan, rd_grp}` holds the slot of period P+3. The memory answers on `rd_oe` in the following cycle, with bit 0 for the even stream and bit 1 for the odd stream. `ctl_o` is never nonzero unless a read was issued three cycles earlier.
- R5: `frame_pulse` is high for one cycle, in period 2048. The first pulse after reset aligns the block: the next cycle is period 1, and it fetches slot 13.
- R6: After any alignment, `ctl_o` is 0 in periods 1, 2 and 3, and valid bits start in period 4.
- R7: If `drive_en` is 0 at a clock edge, both control outputs are 0 for the period that edge starts.
- R8: The active-low asynchronous reset holds `ctl_o` at 0 and `rd_en` at 0. After release, both stay at 0 until the first frame pulse.
- R9: A frame pulse outside period 2048, including one during priming, realigns the block: the next period is period 1 and R6 applies again. A pulse in period 2048 leaves the sequence unbroken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock, one period per control bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | Frame marker, high during period 2048 |
| drive_en | input | 1 | Output enable; 0 forces both control lines low |
| rd_oe | input | 2 | Enable bits for the odd and even stream of the addressed pair |
| rd_en | output | 1 | Connection-memory read request |
| rd_chan | output | 9 | Channel number of the read |
| rd_grp | output | 2 | Stream pair of the read |
| ctl_o | output | 2 | Serial control lines: bit 0 for even streams, bit 1 for odd streams |

## Verification
The assertions assume that the connection memory returns `rd_oe` exactly one cycle after a request. They also assume that `frame_pulse` and `drive_en` are synchronous and change only between clock edges. The bench meets the first assumption with a registered memory model that is indexed by the requested stream pair and channel. It drives every input on the falling edge. It lowers `drive_en` one cycle before it asserts reset in mid-run, so the asynchronous reset never collides with a valid bit in flight. It places pulses in period 2048, at an arbitrary mid-frame period, and in period 1 during priming.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
    // pipeline depth from fetch to output: memory read, prefetch, output register
    localparam int FETCH_LEAD = 3;
    // number of serial control lanes
    localparam int LANES = 2;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_PRIME  = 2'd1,
        ST_LOCKED = 2'd2
    } seq_state_e;
endpackage

// File: rtl/hzc_slot_sequencer.sv
module hzc_slot_sequencer
    import hzc_pkg::*;
#(
    parameter int CHANNELS = 512,
    parameter int STREAMS  = 8,
    parameter int ADVANCE  = 10,
    localparam int PAIRS   = STREAMS / LANES,
    localparam int CH_W    = $clog2(CHANNELS),
    localparam int GRP_W   = $clog2(PAIRS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse,
    output logic             rd_en,
    output logic [CH_W-1:0]  rd_chan,
    output logic [GRP_W-1:0] rd_grp,
    output logic             flush
);
    localparam int FRAME   = CHANNELS * PAIRS;
    localparam int FRAME_W = $clog2(FRAME);
    localparam int K0      = (FETCH_LEAD + ADVANCE) % FRAME;
    localparam int PRIME_W = $clog2(FETCH_LEAD) + 1;

    seq_state_e          state_q, state_d;
    logic [FRAME_W-1:0]  cnt_q;
    logic [FRAME_W-1:0]  slot_q;
    logic [PRIME_W-1:0]  prime_q;
    logic                aligned;
    logic                realign;

    assign aligned = (state_q != ST_HUNT) && (cnt_q == FRAME_W'(FRAME - 1));
    assign realign = frame_pulse && !aligned;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:   if (realign) state_d = ST_PRIME;
            ST_PRIME:  if (realign) state_d = ST_PRIME;
                       else if (prime_q == PRIME_W'(FETCH_LEAD - 1)) state_d = ST_LOCKED;
            ST_LOCKED: if (realign) state_d = ST_PRIME;
            default:   state_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            slot_q  <= '0;
            prime_q <= '0;
        end else if (realign) begin
            cnt_q   <= '0;
            slot_q  <= FRAME_W'(K0);
            prime_q <= '0;
        end else if (state_q != ST_HUNT) begin
            cnt_q   <= cnt_q + 1'b1;
            slot_q  <= slot_q + 1'b1;
            if (state_q == ST_PRIME) prime_q <= prime_q + 1'b1;
        end
    end

    always_comb begin
        rd_en   = (state_q != ST_HUNT);
        rd_chan = slot_q[FRAME_W-1:GRP_W];
        rd_grp  = slot_q[GRP_W-1:0];
        flush   = realign;
    end

    // R5
    first_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> (rd_en && {rd_chan, rd_grp} == FRAME_W'(K0)));

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !realign) |=> (rd_en && {rd_chan, rd_grp} == $past({rd_chan, rd_grp}) + FRAME_W'(1)));

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && !frame_pulse) |=> (state_q == ST_LOCKED));
endmodule

// File: rtl/hzc_bit_pipe.sv
module hzc_bit_pipe
    import hzc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             issue,
    input  logic             drive_en,
    input  logic [LANES-1:0] rd_oe,
    output logic [LANES-1:0] ctl_o
);
    logic issued_q;
    logic pref_v_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issued_q <= 1'b0;
            pref_v_q <= 1'b0;
        end else if (flush) begin
            issued_q <= 1'b0;
            pref_v_q <= 1'b0;
        end else begin
            issued_q <= issue;
            pref_v_q <= issued_q;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic pref_q;
        logic out_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pref_q <= 1'b0;
                out_q  <= 1'b0;
            end else if (flush) begin
                pref_q <= 1'b0;
                out_q  <= 1'b0;
            end else begin
                pref_q <= rd_oe[l];
                out_q  <= (pref_v_q && drive_en) ? pref_q : 1'b0;
            end
        end
        assign ctl_o[l] = out_q;
    end

    // R7
    disable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |=> (ctl_o == '0));

    // R6
    flush_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ctl_o == '0));

    // R4
    fetched_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o != '0) |-> $past(issue, 3));
endmodule

// File: rtl/hz_ctl_serializer.sv
module hz_ctl_serializer
    import hzc_pkg::*;
#(
    parameter int CHANNELS = 512,
    parameter int STREAMS  = 8,
    parameter int ADVANCE  = 10,
    localparam int PAIRS   = STREAMS / LANES,
    localparam int CH_W    = $clog2(CHANNELS),
    localparam int GRP_W   = $clog2(PAIRS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse,
    input  logic             drive_en,
    input  logic [LANES-1:0] rd_oe,
    output logic             rd_en,
    output logic [CH_W-1:0]  rd_chan,
    output logic [GRP_W-1:0] rd_grp,
    output logic [LANES-1:0] ctl_o
);
    logic flush;

    hzc_slot_sequencer #(
        .CHANNELS (CHANNELS),
        .STREAMS  (STREAMS),
        .ADVANCE  (ADVANCE)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .rd_en       (rd_en),
        .rd_chan     (rd_chan),
        .rd_grp      (rd_grp),
        .flush       (flush)
    );

    hzc_bit_pipe u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .issue    (rd_en),
        .drive_en (drive_en),
        .rd_oe    (rd_oe),
        .ctl_o    (ctl_o)
    );

    // R8
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctl_o == '0 && !rd_en));
endmodule

// File: tb/tb_hz_ctl_serializer.sv
`timescale 1ns/1ps
module tb_hz_ctl_serializer;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       frame_pulse;
    logic       drive_en;
    logic [1:0] rd_oe = 2'b00;
    logic       rd_en;
    logic [8:0] rd_chan;
    logic [1:0] rd_grp;
    logic [1:0] ctl_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    hz_ctl_serializer dut (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .drive_en(drive_en),
        .rd_oe(rd_oe), .rd_en(rd_en), .rd_chan(rd_chan), .rd_grp(rd_grp), .ctl_o(ctl_o)
    );

    function automatic logic oe_bit(int s, int c);
        return ((c * 5 + s * 11 + (c >> 4)) % 7) < 4;
    endfunction

    // connection memory model: registered read, one cycle latency
    always @(posedge clk)
        if (rd_en) rd_oe <= {oe_bit(2 * rd_grp + 1, rd_chan), oe_bit(2 * rd_grp, rd_chan)};

    // scoreboard queues
    logic [1:0] q_ctl[$];
    bit         q_rd[$];
    int         q_slot[$];
    string      q_tag[$];

    // prediction model state
    bit m_track = 0;
    bit m_mis = 0;
    int m_per = 0;
    int m_fill = 0;

    task automatic predict();
        logic [1:0] e;
        string tg;
        int k;
        if (!rst_n) begin
            m_track = 0; m_fill = 0; m_mis = 0;
            e = 2'b00; tg = "R8";
        end else begin
            if (frame_pulse && !(m_track && m_per == 2048)) begin
                m_mis = m_track; m_track = 1; m_per = 1; m_fill = 3;
            end else if (m_track) begin
                m_per = (m_per == 2048) ? 1 : m_per + 1;
            end
            if (!m_track) begin
                e = 2'b00; tg = "R8";
            end else if (m_fill != 0) begin
                e = 2'b00; tg = m_mis ? "R9" : "R6"; m_fill--;
            end else if (!drive_en) begin
                e = 2'b00; tg = "R7";
            end else begin
                k = (m_per + 9) % 2048;
                e = {oe_bit(2 * (k % 4) + 1, k / 4), oe_bit(2 * (k % 4), k / 4)};
                if (m_per == 2039 || m_per == 2042 || m_per == 12 || m_per == 2036) tg = "R3";
                else if (m_per == 4) tg = "R5";
                else if (e[0] != e[1]) tg = "R1";
                else tg = "R2";
            end
        end
        q_ctl.push_back(e);
        q_rd.push_back(m_track && rst_n);
        q_slot.push_back((m_per + 12) % 2048);
        q_tag.push_back(tg);
    endtask

    always @(posedge clk) predict();

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        #1;
        if (q_ctl.size() > 0) begin
            logic [1:0] e;
            bit r;
            int s;
            string tg;
            e = q_ctl.pop_front(); r = q_rd.pop_front();
            s = q_slot.pop_front(); tg = q_tag.pop_front();
            chk(tg, ctl_o, e);
            r = r && rst_n;
            chk("R4", rd_en, r);
            if (r) chk("R4", {rd_chan, rd_grp}, s);
        end
    end

    task automatic pulse();
        frame_pulse = 1'b1;
        @(negedge clk);
        frame_pulse = 1'b0;
    endtask

    task automatic aligned_frame();
        repeat (2047) @(negedge clk);
        pulse();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; frame_pulse = 1'b0; drive_en = 1'b1;
        repeat (20) @(negedge clk);           // R8 reset state
        rst_n = 1'b1;
        repeat (40) @(negedge clk);           // R8 hunting, no pulse yet
        pulse();                              // R5 first alignment
        aligned_frame();
        aligned_frame();
        repeat (500) @(negedge clk);          // R7 disable window
        drive_en = 1'b0;
        repeat (60) @(negedge clk);
        drive_en = 1'b1;
        repeat (2047 - 560) @(negedge clk);
        pulse();
        repeat (700) @(negedge clk);          // R9 misplaced pulse
        pulse();
        pulse();                              // R9 pulse during priming
        aligned_frame();
        aligned_frame();
        repeat (300) @(negedge clk);          // R8 reset mid-run
        drive_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        drive_en = 1'b1;
        repeat (30) @(negedge clk);
        pulse();
        aligned_frame();
        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule